// File: doc/BRIEF.md
# Row Scan Shifter with Dual-Half Mode

This block is the common-side scanner of a multi-output matrix display driver. A one-bit scan token enters at an edge pin and moves one stage per rising edge of the line pulse, which acts as the block's clock. The token can move toward higher or lower output numbers. The stages can form one full-length chain, or they can be split into two independent half-length chains. When the chain is split, both halves move the same way, and each half has its own entry pin and carry pin.

Four edge pins sit at the ends of the two halves. The direction and split controls decide which pins take a token in and which pins pass the last stage on to the next cascaded device. Every output also gets a two-bit drive-level code. The code is built from the stage's selected bit, the frame polarity and the display-on input. High-voltage level shifting happens outside this block.

Top module: `row_scan_shifter`

## Requirements
- R1: Single chain (`dual_i`=0), `dir_i`=1: each rising edge loads stage 0 from `pin_in_i[0]` and moves stage i-1 into stage i. `pin_out_o[3]` shows the last stage, so a token present before edge k appears there after edge k+N_OUT-1.
- R2: Single chain, `dir_i`=0: each edge loads the last stage from `pin_in_i[3]` and moves stage i+1 into stage i. `pin_out_o[0]` shows stage 0.
- R3: Split (`dual_i`=1), `dir_i`=1: the lower half loads stage 0 from `pin_in_i[0]`, moves upward and shows stage HALF-1 on `pin_out_o[1]`. The upper half loads stage HALF from `pin_in_i[2]`, moves upward and shows the last stage on `pin_out_o[3]`. No bit crosses between the halves.
- R4: Split, `dir_i`=0: the upper half loads the last stage from `pin_in_i[3]` and shows stage HALF on `pin_out_o[2]`. The lower half loads stage HALF-1 from `pin_in_i[1]` and shows stage 0 on `pin_out_o[0]`.
- R5: `pin_oe_o` marks the pins acting as carry outputs. The value is 4'b0001 for single with dir 0, 4'b1000 for single with dir 1, 4'b0101 for split with dir 0 and 4'b1010 for split with dir 1. Any pin not marked drives 0 on `pin_out_o`.
- R6: With `disp_on_i`=1, output i's code on `drv_o[2i+1:2i]` is 2 for frame 0 unselected, 0 for frame 0 selected, 1 for frame 1 unselected and 3 for frame 1 selected. These are the levels V4, V0, V1 and V5.
- R7: With `disp_on_i`=0, every output code is 3 (V5), whatever the stage state and frame.
- R8: A synchronous reset clears every stage to unselected.
- R9: Values on pins that are not the entry pins of the current mode have no effect on any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line pulse; stages move on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dual_i | input | 1 | 1 = two independent half chains |
| dir_i | input | 1 | 1 = move toward higher output numbers |
| frame_i | input | 1 | Frame polarity |
| disp_on_i | input | 1 | 0 forces every output to the V5 code |
| pin_in_i | input | 4 | Edge pin inputs: [0] output-1 end, [1] top of lower half, [2] bottom of upper half, [3] last-output end |
| pin_out_o | output | 4 | Edge pin carry values |
| pin_oe_o | output | 4 | Edge pin output enables |
| drv_o | output | 2*N_OUT | Per-output level codes, two bits each |

## Verification
Each of the four split and direction combinations is driven with per-pin bit streams that differ in period and phase. A bit that lands in the wrong stage, crosses between the halves or comes from the wrong pin therefore shows up as a mismatch. The bench also drives noise on the pins that should act as outputs, which separates a correct entry-pin choice from one that listens to the wrong end. After every edge, both frame polarities and the display-off state are applied. Together they cover all four level codes for selected and unselected stages, and they confirm that display-off overrides everything else.

// File: rtl/rss_pkg.sv
package rss_pkg;

   typedef enum logic [1:0] {
      LV_V0 = 2'd0,
      LV_V1 = 2'd1,
      LV_V4 = 2'd2,
      LV_V5 = 2'd3
   } drv_lvl_e;

   localparam int unsigned EDGE_PINS = 4;

   // level chosen from frame polarity, selection bit and display enable
   function automatic drv_lvl_e lvl_of(input logic frame, input logic sel, input logic on);
      drv_lvl_e r;
      if (!on)          r = LV_V5;
      else if (!frame)  r = sel ? LV_V0 : LV_V4;
      else              r = sel ? LV_V5 : LV_V1;
      return r;
   endfunction

endpackage

// File: rtl/rss_chain.sv
module rss_chain #(
   parameter int unsigned N_OUT = 160
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dual,
   input  logic             dir,
   input  logic [3:0]       pin_in,
   output logic [N_OUT-1:0] st_q
);
   localparam int unsigned HALF = N_OUT / 2;

   logic [N_OUT-1:0] nxt;

   for (genvar i = 0; i < N_OUT; i++) begin : g_stage
      logic up_src;
      logic dn_src;
      // source when moving toward higher indices
      if (i == 0) begin : g_up_entry
         assign up_src = pin_in[0];
      end else if (i == HALF) begin : g_up_mid
         assign up_src = dual ? pin_in[2] : st_q[i-1];
      end else begin : g_up_link
         assign up_src = st_q[i-1];
      end
      // source when moving toward lower indices
      if (i == N_OUT-1) begin : g_dn_entry
         assign dn_src = pin_in[3];
      end else if (i == HALF-1) begin : g_dn_mid
         assign dn_src = dual ? pin_in[1] : st_q[i+1];
      end else begin : g_dn_link
         assign dn_src = st_q[i+1];
      end
      assign nxt[i] = dir ? up_src : dn_src;
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= '0;
      else     st_q <= nxt;
   end
endmodule

// File: rtl/rss_pin_map.sv
module rss_pin_map (
   input  logic       dual,
   input  logic       dir,
   input  logic       end_lo,
   input  logic       end_mlo,
   input  logic       end_mhi,
   input  logic       end_hi,
   output logic [3:0] pin_oe,
   output logic [3:0] pin_out
);
   always_comb begin
      unique case ({dual, dir})
         2'b00:   pin_oe = 4'b0001;
         2'b01:   pin_oe = 4'b1000;
         2'b10:   pin_oe = 4'b0101;
         default: pin_oe = 4'b1010;
      endcase
      pin_out = {end_hi, end_mhi, end_mlo, end_lo} & pin_oe;
   end
endmodule

// File: rtl/rss_level_enc.sv
module rss_level_enc
   import rss_pkg::*;
#(
   parameter int unsigned N_OUT = 160
) (
   input  logic               frame,
   input  logic               disp_on,
   input  logic [N_OUT-1:0]   sel,
   output logic [2*N_OUT-1:0] drv
);
   for (genvar i = 0; i < N_OUT; i++) begin : g_enc
      drv_lvl_e lv;
      assign lv = lvl_of(frame, sel[i], disp_on);
      assign drv[2*i +: 2] = lv;
   end
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
   parameter int unsigned N_OUT = 160
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               dual_i,
   input  logic               dir_i,
   input  logic               frame_i,
   input  logic               disp_on_i,
   input  logic [3:0]         pin_in_i,
   output logic [3:0]         pin_out_o,
   output logic [3:0]         pin_oe_o,
   output logic [2*N_OUT-1:0] drv_o
);
   localparam int unsigned HALF = N_OUT / 2;

   if ((N_OUT % 2) != 0) begin : g_bad_odd
      $error("N_OUT must be even");
   end
   if (N_OUT < 4) begin : g_bad_small
      $error("N_OUT must be at least 4");
   end

   logic [N_OUT-1:0] stage_q;

   rss_chain #(.N_OUT(N_OUT)) u_chain (
      .clk    (clk),
      .rst    (rst),
      .dual   (dual_i),
      .dir    (dir_i),
      .pin_in (pin_in_i),
      .st_q   (stage_q)
   );

   rss_pin_map u_pins (
      .dual    (dual_i),
      .dir     (dir_i),
      .end_lo  (stage_q[0]),
      .end_mlo (stage_q[HALF-1]),
      .end_mhi (stage_q[HALF]),
      .end_hi  (stage_q[N_OUT-1]),
      .pin_oe  (pin_oe_o),
      .pin_out (pin_out_o)
   );

   rss_level_enc #(.N_OUT(N_OUT)) u_enc (
      .frame   (frame_i),
      .disp_on (disp_on_i),
      .sel     (stage_q),
      .drv     (drv_o)
   );
endmodule

// File: rtl/row_scan_shifter_chk.sv
module row_scan_shifter_chk #(
   parameter int unsigned N_OUT = 160
) (
   input logic               clk,
   input logic               rst,
   input logic               dual_i,
   input logic               dir_i,
   input logic               disp_on_i,
   input logic [3:0]         pin_in_i,
   input logic [3:0]         pin_out_o,
   input logic [3:0]         pin_oe_o,
   input logic [2*N_OUT-1:0] drv_o,
   input logic [N_OUT-1:0]   stage_q
);
   localparam int unsigned HALF = N_OUT / 2;

   AST_SINGLE_UP: assert property (@(posedge clk) disable iff (rst)
      (!dual_i && dir_i) |=> stage_q == {$past(stage_q[N_OUT-2:0]), $past(pin_in_i[0])}); // R1
   AST_SINGLE_UP_CARRY: assert property (@(posedge clk) disable iff (rst)
      (!dual_i && dir_i) |-> pin_out_o[3] == stage_q[N_OUT-1]); // R1
   AST_SINGLE_DN: assert property (@(posedge clk) disable iff (rst)
      (!dual_i && !dir_i) |=> stage_q == {$past(pin_in_i[3]), $past(stage_q[N_OUT-1:1])}); // R2
   AST_DUAL_UP: assert property (@(posedge clk) disable iff (rst)
      (dual_i && dir_i) |=> stage_q == {$past(stage_q[N_OUT-2:HALF]), $past(pin_in_i[2]),
                                         $past(stage_q[HALF-2:0]), $past(pin_in_i[0])}); // R3
   AST_DUAL_DN: assert property (@(posedge clk) disable iff (rst)
      (dual_i && !dir_i) |=> stage_q == {$past(pin_in_i[3]), $past(stage_q[N_OUT-1:HALF+1]),
                                          $past(pin_in_i[1]), $past(stage_q[HALF-1:1])}); // R4
   AST_OE_COUNT: assert property (@(posedge clk) disable iff (rst)
      dual_i ? ($countones(pin_oe_o) == 2) : ($countones(pin_oe_o) == 1)); // R5
   AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
      (pin_out_o & ~pin_oe_o) == 4'b0000); // R5
   AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (rst)
      !disp_on_i |-> drv_o == {N_OUT{2'b11}}); // R7
   AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> stage_q == '0); // R8
endmodule

bind row_scan_shifter row_scan_shifter_chk #(.N_OUT(N_OUT)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .dual_i    (dual_i),
   .dir_i     (dir_i),
   .disp_on_i (disp_on_i),
   .pin_in_i  (pin_in_i),
   .pin_out_o (pin_out_o),
   .pin_oe_o  (pin_oe_o),
   .drv_o     (drv_o),
   .stage_q   (stage_q)
);

// File: tb/row_scan_shifter_bench.sv
module row_scan_shifter_bench;
   localparam int N = 8;
   localparam int H = N / 2;
   localparam int STEPS = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dual = 1'b0;
   logic dir = 1'b0;
   logic frame = 1'b0;
   logic disp_on = 1'b1;
   logic [3:0] pin_in = 4'b0;
   logic [3:0] pin_out;
   logic [3:0] pin_oe;
   logic [2*N-1:0] drv;

   int errors = 0;
   int checks = 0;
   logic hist [4][0:31];

   always #4 clk = ~clk;

   row_scan_shifter #(.N_OUT(N)) u_row_scan_shifter (
      .clk       (clk),
      .rst       (rst),
      .dual_i    (dual),
      .dir_i     (dir),
      .frame_i   (frame),
      .disp_on_i (disp_on),
      .pin_in_i  (pin_in),
      .pin_out_o (pin_out),
      .pin_oe_o  (pin_oe),
      .drv_o     (drv)
   );

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic pat(input int p, input int k, input int m);
      return (((k * (p + 3)) + p + m) % (p + 2)) == 0;
   endfunction

   // level code from R6/R7
   function automatic logic [1:0] code(input logic f, input logic s, input logic on);
      if (!on) return 2'd3;
      if (!f)  return s ? 2'd0 : 2'd2;
      return s ? 2'd3 : 2'd1;
   endfunction

   // expected stage value after k edges since reset, from R1-R4
   function automatic logic exp_stage(input int i, input int k);
      int p;
      int d;
      if (!dual && dir)       begin p = 0; d = i; end
      else if (!dual && !dir) begin p = 3; d = N - 1 - i; end
      else if (dir) begin
         if (i < H) begin p = 0; d = i; end
         else       begin p = 2; d = i - H; end
      end else begin
         if (i >= H) begin p = 3; d = N - 1 - i; end
         else        begin p = 1; d = H - 1 - i; end
      end
      return (k > d) ? hist[p][k-d] : 1'b0;
   endfunction

   function automatic logic [3:0] exp_oe();
      case ({dual, dir})
         2'b00:   return 4'b0001;
         2'b01:   return 4'b1000;
         2'b10:   return 4'b0101;
         default: return 4'b1010;
      endcase
   endfunction

   task automatic check_all(input string req, input int k);
      logic [2*N-1:0] e;
      logic [3:0] oe;
      logic [3:0] po;
      for (int f = 0; f < 2; f++) begin
         frame = f[0];
         #1;
         for (int i = 0; i < N; i++) e[2*i +: 2] = code(f[0], exp_stage(i, k), 1'b1);
         check({req, "+R6+R9"}, drv, e);
      end
      disp_on = 1'b0;
      #1;
      check("R7", drv, {N{2'b11}});
      disp_on = 1'b1;
      oe = exp_oe();
      po[0] = oe[0] & exp_stage(0, k);
      po[1] = oe[1] & exp_stage(H - 1, k);
      po[2] = oe[2] & exp_stage(H, k);
      po[3] = oe[3] & exp_stage(N - 1, k);
      check("R5", {{(2*N-4){1'b0}}, pin_oe}, {{(2*N-4){1'b0}}, oe});
      check({req, "+R5 carry"}, {{(2*N-4){1'b0}}, pin_out}, {{(2*N-4){1'b0}}, po});
   endtask

   initial begin
      string req;
      for (int m = 0; m < 4; m++) begin
         @(negedge clk);
         rst = 1'b1;
         dual = m[1];
         dir = m[0];
         pin_in = 4'b1111;
         @(posedge clk);
         @(negedge clk);
         rst = 1'b0;
         for (int p = 0; p < 4; p++) hist[p][0] = 1'b0;
         // R8: reset leaves every stage unselected
         check_all("R8", 0);
         case (m)
            0: req = "R2";
            1: req = "R1";
            2: req = "R4";
            default: req = "R3";
         endcase
         for (int k = 1; k <= STEPS; k++) begin
            for (int p = 0; p < 4; p++) begin
               hist[p][k] = pat(p, k, m);
               pin_in[p] = hist[p][k];
            end
            @(posedge clk);
            @(negedge clk);
            check_all(req, k);
         end
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule